// File: doc/BRIEF.md
# TDM Channel Selector with Stereo Serial Audio Output

The block listens to a time-division multiplexed audio stream that carries eight microphone channels on one serial data line. The stream comes with a bit clock and a word-select marker. The block rebuilds the eight signed PCM samples of every frame. From each frame it forms one output sample, which is either one chosen channel or the mean of all eight. It sends that sample as a standard two-channel I2S stream to a headphone DAC, with the same value in the left word and in the right word.

A single push button selects the output. Each full press and release steps through a ring of nine modes: the mean of all channels first, then slot 1 through slot 8, then back to the mean. A status LED shows when the mean is being played, and it also lights while the button is held down. All logic runs on one system clock. The serial inputs and the button are resynchronised to that clock inside the block. The output bit clock is derived from the input bit rate, so one output frame is sent for each input frame.

Top module: `tdm_stereo_sel`

## Requirements
- R1: An input frame is 128 bit clocks long and holds eight 16-bit two's-complement slots. Each slot is sent MSB first, and data is taken on the rising edge of `tdm_sck`. `tdm_ws` is high during exactly one bit, which is the last bit of slot 8. Slot 1 begins with the next bit. Frames are decoded only after the first word-select pulse has been seen.
- R2: The output frame is 64 `out_sck` periods long, and one `out_sck` period equals two input bit periods. `out_ws` is low for the left word and high for the right word, and each word is 32 bits long. The 16 sample bits follow MSB first, starting one bit after the `out_ws` transition. All remaining bits are zero. `out_ws` and `out_sd` change only on the falling edge of `out_sck`.
- R3: The left word and the right word of every output frame carry the same sample.
- R4: In mode 0 (all channels), the sample is the 19-bit signed sum of the eight slots, shifted right arithmetically by 3, with the low 16 bits kept. This equals the floor of the mean.
- R5: Modes are encoded 0 for all channels and k for slot k, where k runs from 1 to 8. Mode 0 is selected after reset.
- R6: `mode_btn` is active high. A level change counts only after the synchronised level has stayed stable for DEB_CYCLES clocks. Shorter pulses have no effect on the mode.
- R7: The mode advances by one step around the ring 0→1→…→8→0 on a debounced release only. A press alone does not change the mode, even if it is held across frames.
- R8: `mode_led` is high when the mode in effect is 0, or when the debounced button level is pressed.
- R9: A new mode takes effect only when an input frame completes. Each output frame is built from one input frame and one mode.
- R10: The output frame that carries input frame k starts immediately after the word-select bit of frame k. Until the first frame has been decoded, the output sends zero samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdm_sck | input | 1 | Input TDM bit clock |
| tdm_ws | input | 1 | Input frame marker, high on the last bit of the frame |
| tdm_sd | input | 1 | Input TDM serial data |
| mode_btn | input | 1 | Mode push button, high while pressed |
| out_sck | output | 1 | Output I2S bit clock |
| out_ws | output | 1 | Output I2S word select, low for left |
| out_sd | output | 1 | Output I2S serial data |
| mode_led | output | 1 | Mode status LED |

## Verification
The sample built from input frame k is due in the output frame that starts right after frame k's word-select bit. The bench decodes the output the way a DAC does, by sampling on each rising edge of `out_sck`, and matches each received frame against the list of expected frames in order. This makes the checks independent of the clock-domain delay. A button release takes effect at the next frame boundary, which comes at least DEB_CYCLES plus three clocks after the release. For this reason the bench presses the button early in a frame, keeps the whole debounce window inside that frame, and expects the new mode from that same frame onward. A long hold that crosses a boundary is expected to change the mode only in the frame that follows. The LED is checked a few bits into each frame, after the previous boundary has settled, and again in the middle of a hold, well after the debounce delay has passed.

// File: rtl/tdmsel_pkg.sv
package tdmsel_pkg;
   // next mode in the ring: 0 = all channels, 1..n = single slot
   function automatic int unsigned ring_next(input int unsigned m, input int unsigned n);
      return (m >= n) ? 0 : m + 1;
   endfunction
endpackage

// File: rtl/tdm_slot_deser.sv
module tdm_slot_deser #(
   parameter int W = 16,
   parameter int N = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sck_i,
   input  logic                          ws_i,
   input  logic                          sd_i,
   output logic [N*W-1:0]                frame_o,
   output logic                          done_o,
   output logic                          run_o,
   output logic [$clog2(N*W)-1:0]        phase_o
);
   localparam int FRAME_BITS = N * W;
   localparam int CW = $clog2(FRAME_BITS);
   localparam int LW = $clog2(W);
   localparam int SW = $clog2(N);

   logic [2:0]    sck_s, ws_s, sd_s;
   logic          tick, ws_b, sd_b;
   logic [CW-1:0] cnt;
   logic [W-1:0]  shreg;
   logic          locked;
   logic [W-1:0]  cap [N];

   // three-stage capture, all inputs delayed alike
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_s <= '0;
         ws_s  <= '0;
         sd_s  <= '0;
      end else begin
         sck_s <= {sck_s[1:0], sck_i};
         ws_s  <= {ws_s[1:0], ws_i};
         sd_s  <= {sd_s[1:0], sd_i};
      end
   end

   assign tick = sck_s[1] & ~sck_s[2];
   assign ws_b = ws_s[1];
   assign sd_b = sd_s[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         shreg  <= '0;
         locked <= 1'b0;
         done_o <= 1'b0;
         for (int i = 0; i < N; i++) cap[i] <= '0;
      end else begin
         done_o <= tick & ws_b & locked;
         if (tick) begin
            shreg <= {shreg[W-2:0], sd_b};
            if (cnt[LW-1:0] == LW'(W - 1))
               cap[cnt[CW-1:LW]] <= {shreg[W-2:0], sd_b};
            cnt <= ws_b ? '0 : cnt + 1'b1;
            if (ws_b) locked <= 1'b1;
         end
      end
   end

   assign run_o   = tick & (locked | ws_b);
   assign phase_o = ws_b ? '0 : cnt + 1'b1;

   for (genvar i = 0; i < N; i++) begin : g_flat
      assign frame_o[i*W +: W] = cap[i];
   end

   // R1: a marker seen while locked must fall on the last bit of the frame
   a_r1_ws_on_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ws_b && locked) |-> (cnt == CW'(FRAME_BITS - 1)));
   // R9: frame completion is a single-cycle event
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   localparam int unused_sw = SW;
endmodule

// File: rtl/mode_seq.sv
module mode_seq #(
   parameter int N          = 8,
   parameter int DEB_CYCLES = 50000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    btn_i,
   input  logic [$clog2(N+1)-1:0]  mode_act_i,
   output logic [$clog2(N+1)-1:0]  mode_req_o,
   output logic                    led_o
);
   import tdmsel_pkg::*;
   localparam int MW  = $clog2(N + 1);
   localparam int DBW = $clog2(DEB_CYCLES + 1);

   logic [1:0]     btn_s;
   logic           db;
   logic [DBW-1:0] dcnt;
   logic           settle;

   assign settle = (btn_s[1] != db) && (dcnt == DBW'(DEB_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         btn_s      <= '0;
         db         <= 1'b0;
         dcnt       <= '0;
         mode_req_o <= '0;
      end else begin
         btn_s <= {btn_s[0], btn_i};
         if (btn_s[1] == db) begin
            dcnt <= '0;
         end else if (settle) begin
            dcnt <= '0;
            db   <= btn_s[1];
            if (db) mode_req_o <= MW'(ring_next(int'(mode_req_o), N));
         end else begin
            dcnt <= dcnt + 1'b1;
         end
      end
   end

   assign led_o = (mode_act_i == '0) | db;

   // R6: debounced level only follows a synchroniser level held beforehand
   a_r6_debounce_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(db) |-> ($past(btn_s[1], 1) == db && $past(btn_s[1], 2) == db));
   // R7: mode moves only together with a debounced release
   a_r7_step_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(mode_req_o) |-> $fell(db));
   // R5: mode code stays inside the ring
   a_r5_mode_range: assert property (@(posedge clk) disable iff (!rst_n)
      mode_req_o <= MW'(N));
endmodule

// File: rtl/chan_pick.sv
module chan_pick #(
   parameter int W = 16,
   parameter int N = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N*W-1:0]          frame_i,
   input  logic                    done_i,
   input  logic [$clog2(N+1)-1:0]  mode_req_i,
   output logic [$clog2(N+1)-1:0]  mode_act_o,
   output logic [W-1:0]            sample_o
);
   localparam int MW   = $clog2(N + 1);
   localparam int LN   = $clog2(N);
   localparam int SUMW = W + LN;

   logic [W-1:0]           slot [N];
   logic signed [SUMW-1:0] sum;
   logic [SUMW-1:0]        shifted;
   logic [W-1:0]           avg, picked;

   for (genvar i = 0; i < N; i++) begin : g_slot
      assign slot[i] = frame_i[i*W +: W];
   end

   always_comb begin
      sum    = '0;
      picked = '0;
      for (int i = 0; i < N; i++) begin
         sum = sum + $signed({{LN{slot[i][W-1]}}, slot[i]});
         if (mode_req_i == MW'(i + 1)) picked = slot[i];
      end
      shifted = sum >>> LN;
      avg     = shifted[W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_act_o <= '0;
         sample_o   <= '0;
      end else if (done_i) begin
         mode_act_o <= mode_req_i;
         sample_o   <= (mode_req_i == '0) ? avg : picked;
      end
   end

   // R9: mode and sample move only at a completed input frame
   a_r9_mode_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      !done_i |=> ($stable(mode_act_o) && $stable(sample_o)));
endmodule

// File: rtl/i2s_stereo_tx.sv
module i2s_stereo_tx #(
   parameter int W  = 16,
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic [CW-1:0] phase_i,
   input  logic [W-1:0]  sample_i,
   output logic          sck_o,
   output logic          ws_o,
   output logic          sd_o
);
   localparam int QW = CW - 2;
   localparam int BW = $clog2(W);

   logic [QW-1:0] q;
   logic          in_word;
   logic [BW-1:0] bidx;

   assign q = phase_i[CW-2:1];

   always_comb begin
      in_word = (int'(q) >= 1) && (int'(q) <= W);
      bidx    = in_word ? BW'(W - int'(q)) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_o <= 1'b0;
         ws_o  <= 1'b0;
         sd_o  <= 1'b0;
      end else if (run_i) begin
         if (!phase_i[0]) begin
            sck_o <= 1'b0;
            ws_o  <= phase_i[CW-1];
            sd_o  <= in_word ? sample_i[bidx] : 1'b0;
         end else begin
            sck_o <= 1'b1;
         end
      end
   end

   // R2: word select and data hold steady across the rising edge
   a_r2_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck_o) |-> ($stable(ws_o) && $stable(sd_o)));
endmodule

// File: rtl/tdm_stereo_sel.sv
module tdm_stereo_sel #(
   parameter int W          = 16,
   parameter int N          = 8,
   parameter int DEB_CYCLES = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tdm_sck,
   input  logic tdm_ws,
   input  logic tdm_sd,
   input  logic mode_btn,
   output logic out_sck,
   output logic out_ws,
   output logic out_sd,
   output logic mode_led
);
   localparam int FRAME_BITS = N * W;
   localparam int CW         = $clog2(FRAME_BITS);
   localparam int MW         = $clog2(N + 1);
   localparam int OUT_SLOT   = FRAME_BITS / 4;

   if ((1 << $clog2(W)) != W || W < 2) begin : g_chk_w
      $error("W must be a power of two");
   end
   if ((1 << $clog2(N)) != N || N < 2) begin : g_chk_n
      $error("N must be a power of two of at least 2");
   end
   if (OUT_SLOT < W + 1) begin : g_chk_slot
      $error("output word slot too short for one delay bit plus sample");
   end
   if (DEB_CYCLES < 2) begin : g_chk_deb
      $error("DEB_CYCLES must be at least 2");
   end

   logic [N*W-1:0] frame;
   logic           done, run;
   logic [CW-1:0]  phase;
   logic [MW-1:0]  mode_req, mode_act;
   logic [W-1:0]   sample;

   tdm_slot_deser #(.W(W), .N(N)) u_deser (
      .clk(clk), .rst_n(rst_n), .sck_i(tdm_sck), .ws_i(tdm_ws), .sd_i(tdm_sd),
      .frame_o(frame), .done_o(done), .run_o(run), .phase_o(phase));

   mode_seq #(.N(N), .DEB_CYCLES(DEB_CYCLES)) u_mode (
      .clk(clk), .rst_n(rst_n), .btn_i(mode_btn), .mode_act_i(mode_act),
      .mode_req_o(mode_req), .led_o(mode_led));

   chan_pick #(.W(W), .N(N)) u_pick (
      .clk(clk), .rst_n(rst_n), .frame_i(frame), .done_i(done),
      .mode_req_i(mode_req), .mode_act_o(mode_act), .sample_o(sample));

   i2s_stereo_tx #(.W(W), .CW(CW)) u_tx (
      .clk(clk), .rst_n(rst_n), .run_i(run), .phase_i(phase), .sample_i(sample),
      .sck_o(out_sck), .ws_o(out_ws), .sd_o(out_sd));

   // R8: all-channels mode in effect keeps the LED lit
   a_r8_led_all: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_act == '0) |-> mode_led);
endmodule

// File: tb/tdm_stereo_sel_test.sv
module tdm_stereo_sel_test;
   localparam int W = 16;
   localparam int N = 8;
   localparam int DEB = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tdm_sck = 1'b0, tdm_ws = 1'b0, tdm_sd = 1'b0, mode_btn = 1'b0;
   logic out_sck, out_ws, out_sd, mode_led;

   always #2 clk = ~clk;

   tdm_stereo_sel #(.W(W), .N(N), .DEB_CYCLES(DEB)) uut (
      .clk(clk), .rst_n(rst_n), .tdm_sck(tdm_sck), .tdm_ws(tdm_ws), .tdm_sd(tdm_sd),
      .mode_btn(mode_btn), .out_sck(out_sck), .out_ws(out_ws), .out_sd(out_sd),
      .mode_led(mode_led));

   int checks = 0, fails = 0;
   logic [15:0] smp [8];
   logic [15:0] exp_w [64];
   int exp_n = 0;
   logic [15:0] rx_l [64], rx_r [64];
   int rx_n = 0;
   int cur_mode = 0, prev_mode = 0;
   bit pend = 0, hold_over = 0;
   int unsigned seed = 32'h5EED_1234;
   bit done_flag = 0;

   function automatic logic [15:0] avg_of(input logic [15:0] s [8]);
      int acc = 0;
      for (int i = 0; i < 8; i++) acc += int'($signed(s[i]));
      acc = acc >>> 3;
      return acc[15:0];
   endfunction

   function automatic logic [15:0] pick(input logic [15:0] s [8], input int m);
      return (m == 0) ? avg_of(s) : s[m-1];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // DAC-like receiver: samples on out_sck rising edges
   bit prev_ws = 1'b1;
   int pos = 0;
   logic [15:0] wl = '0, wr = '0;
   always @(posedge out_sck) begin
      if (out_ws != prev_ws) pos = 0; else pos = pos + 1;
      prev_ws = out_ws;
      if (pos >= 1 && pos <= 16) begin
         if (out_ws) wr[16-pos] = out_sd; else wl[16-pos] = out_sd;
      end
      if (out_ws && pos == 16 && rx_n < 64) begin
         rx_l[rx_n] = wl;
         rx_r[rx_n] = wr;
         rx_n = rx_n + 1;
      end
   end

   task automatic press_step();
      mode_btn = 1'b1;
      repeat (50) @(negedge clk);
      check("R8 led while held", {31'd0, mode_led}, 32'd1);
      repeat (10) @(negedge clk);
      mode_btn = 1'b0;
   endtask

   task automatic press_bounce();
      for (int i = 0; i < 3; i++) begin
         mode_btn = 1'b1;
         repeat (5) @(negedge clk);
         mode_btn = 1'b0;
         repeat (5) @(negedge clk);
      end
   endtask

   task automatic press_long();
      mode_btn = 1'b1;
      repeat (1000) @(negedge clk);
      mode_btn = 1'b0;
   endtask

   // act: 0 none, 1 step press, 2 bounce (R6), 3 hold across boundary (R7)
   task automatic send_frame(input int act, input bit record);
      bit held_now;
      held_now = hold_over;
      hold_over = 0;
      if (pend) begin cur_mode = (cur_mode + 1) % 9; pend = 0; end
      if (act == 1) cur_mode = (cur_mode + 1) % 9;
      if (act == 3) begin pend = 1; hold_over = 1; end
      if (record) begin exp_w[exp_n] = pick(smp, cur_mode); exp_n++; end
      for (int b = 0; b < 128; b++) begin
         tdm_sd  = smp[b/16][15 - (b % 16)];
         tdm_ws  = (b == 127);
         tdm_sck = 1'b0;
         if (b == 4)
            check("R8 led state", {31'd0, mode_led},
                  {31'd0, (prev_mode == 0) || held_now});
         if (b == 8) begin
            if (act == 1) fork press_step(); join_none
            if (act == 2) fork press_bounce(); join_none
            if (act == 3) fork press_long(); join_none
         end
         repeat (3) @(negedge clk);
         tdm_sck = 1'b1;
         repeat (3) @(negedge clk);
      end
      prev_mode = cur_mode;
   endtask

   task automatic rand_smp();
      for (int i = 0; i < 8; i++) smp[i] = 16'($urandom(seed) & 32'hFFFF);
      seed = seed + 32'd7919;
   endtask

   initial begin
      for (int i = 0; i < 8; i++) smp[i] = '0;
      repeat (10) @(negedge clk);
      check("R5 reset led", {31'd0, mode_led}, 32'd1);
      check("R2 reset outputs", {29'd0, out_sck, out_ws, out_sd}, 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      exp_w[0] = '0; exp_n = 1;            // R10: zero frame before first decode
      rand_smp(); send_frame(0, 0);        // R1: lock frame, no output of its own
      rand_smp(); send_frame(0, 1);        // R4 random average
      for (int i = 0; i < 8; i++) smp[i] = 16'h7FFF;
      send_frame(0, 1);                    // R4 maximum
      for (int i = 0; i < 8; i++) smp[i] = 16'h8000;
      send_frame(0, 1);                    // R4 minimum
      for (int i = 0; i < 8; i++) smp[i] = '0;
      smp[5] = 16'hFFFF;
      send_frame(0, 1);                    // R4 floor of -1/8
      rand_smp(); send_frame(0, 1);
      for (int k = 0; k < 9; k++) begin    // R5 R7 full ring
         rand_smp(); send_frame(1, 1);
         rand_smp(); send_frame(0, 1);
      end
      for (int k = 0; k < 3; k++) begin rand_smp(); send_frame(1, 1); end
      rand_smp(); send_frame(2, 1);        // R6 bounce ignored
      rand_smp(); send_frame(0, 1);
      rand_smp(); send_frame(3, 1);        // R7 hold over boundary
      rand_smp(); send_frame(0, 1);
      rand_smp(); send_frame(0, 1);
      for (int b = 0; b < 110; b++) begin
         tdm_sd = 1'b0; tdm_ws = 1'b0; tdm_sck = 1'b0;
         repeat (3) @(negedge clk);
         tdm_sck = 1'b1;
         repeat (3) @(negedge clk);
      end
      check("R10 frame count", rx_n, exp_n);
      for (int j = 0; j < exp_n && j < rx_n; j++) begin
         check("R9 R4 R2 left word", {16'd0, rx_l[j]}, {16'd0, exp_w[j]});
         check("R3 right equals left", {16'd0, rx_r[j]}, {16'd0, exp_w[j]});
      end
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule